// File: doc/BRIEF.md
# Dithered Fractional Tick Generator

This block derives a 1 kHz system tick from a slow standby clock whose frequency is not an integer multiple of 1 kHz, such as a 32.768 kHz crystal. A reload down-counter measures out each tick in whole input cycles. Every tick therefore lasts either a base count of cycles or one cycle more. At each reload a fixed-point phase accumulator decides which of the two lengths the next tick gets, so the long-run average period is exact.

In plain mode every tick lasts the base count. With a base of 32 at 32.768 kHz a tick is 250/256 ms, about 0.976 ms, and 60000 ticks take roughly 58.6 s. In corrected mode the accumulator adds a fraction numerator modulo a denominator at every reload. Each time it wraps, the following tick is stretched to base+1 cycles, which is about 1.007 ms at the default settings. The outputs are a one-cycle tick pulse and a running tick count.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, tick_o is 0 and tick_count_o is 0. With en_i held high, the first tick pulse appears exactly base_i enabled cycles after reset is released. Reset clears the accumulator.
- R2: tick_o is high for exactly one cycle per tick. tick_count_o increases by exactly one in the same cycle in which tick_o goes high.
- R3: With mode_i = 0 (plain), the distance between consecutive tick pulses is exactly base_i cycles, and the accumulator is held.
- R4: With mode_i = 1 (corrected), each reload forms s = acc + frac_num_i. If s >= frac_den_i, acc becomes s - frac_den_i and the next tick lasts base_i+1 cycles. Otherwise acc becomes s and the next tick lasts base_i cycles. No tick has any other length.
- R5: With base 32, numerator 768 and denominator 1000 in corrected mode, any 1000 consecutive ticks contain exactly 768 ticks of 33 cycles and 232 ticks of 32 cycles, for 32768 cycles in total.
- R6: mode_i, base_i, frac_num_i and frac_den_i are sampled only at a reload. A change in the middle of a tick leaves that tick's length unchanged.
- R7: While en_i is low, the countdown is frozen and no tick is produced. A tick interrupted by k disabled cycles ends k cycles later than it otherwise would.
- R8: tick_count_o is TCNT_W bits wide and wraps from all ones to zero without any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable |
| mode_i | input | 1 | 0 = plain, 1 = corrected (dithered) |
| base_i | input | CNT_W | Base tick length in input cycles |
| frac_num_i | input | FRAC_W | Accumulator increment per tick |
| frac_den_i | input | FRAC_W | Accumulator modulus |
| tick_o | output | 1 | One-cycle tick pulse |
| tick_count_o | output | TCNT_W | Running tick count |

## Verification
The assertions rely on a few conditions on the inputs:
- base_i is at least 2, so that tick pulses cannot sit back to back.
- frac_den_i is nonzero and exceeds frac_num_i.
- The accumulator never holds a value at or above the current denominator. This means the denominator is only lowered across a reset.

The stimulus respects all of these. It uses bases of 3 or more. It sweeps every numerator below a fixed denominator of 7. It changes the denominator (1000 versus 7) only while reset is asserted.

// File: rtl/frac_tick_pkg.sv
`timescale 1ns/1ps
package frac_tick_pkg;
  typedef enum logic {
    TICK_PLAIN = 1'b0,
    TICK_TRIM  = 1'b1
  } tick_mode_e;
endpackage

// File: rtl/tick_phase_accum.sv
`timescale 1ns/1ps
module tick_phase_accum
  import frac_tick_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  tick_mode_e        mode_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  output logic              stretch_o
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  den_x;
  logic [SUM_W-1:0]  rem;
  logic              wrap;

  always_comb begin
    sum       = {1'b0, acc_q} + {1'b0, num_i};
    den_x     = {1'b0, den_i};
    rem       = sum - den_x;
    wrap      = (mode_i == TICK_TRIM) && (sum >= den_x);
    stretch_o = wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (adv_i && (mode_i == TICK_TRIM)) begin
      acc_q <= wrap ? rem[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end
  end

  // R4: the phase only moves at a reload
  a_r4_phase_moves_on_reload: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(acc_q));

  // R3: a plain-mode reload leaves the phase untouched
  a_r3_phase_held_plain: assert property (@(posedge clk) disable iff (rst)
    (adv_i && (mode_i == TICK_PLAIN)) |=> $stable(acc_q));

  // R4: the phase stays below the modulus (input assumption: den not lowered without reset)
  a_r4_phase_below_den: assert property (@(posedge clk) disable iff (rst)
    (adv_i && (mode_i == TICK_TRIM)) |=> (acc_q < $past(den_i)));
endmodule

// File: rtl/tick_down_counter.sv
`timescale 1ns/1ps
module tick_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic             stretch_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  always_comb expire_o = en_i && (remain_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= base_i - ONE;
    end else if (expire_o) begin
      remain_q <= stretch_i ? base_i : (base_i - ONE);
    end else if (en_i) begin
      remain_q <= remain_q - ONE;
    end
  end

  // R7: no movement while disabled
  a_r7_freeze_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(remain_q));

  // R4: a reload picks base or base+1 cycles only
  a_r4_reload_two_lengths: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> ((remain_q == $past(base_i)) || (remain_q == ($past(base_i) - ONE))));

  // R6: between reloads the count never climbs, whatever base_i does
  a_r6_no_midtick_reload: assert property (@(posedge clk) disable iff (rst)
    !expire_o |=> (remain_q <= $past(remain_q)));
endmodule

// File: rtl/tick_event_counter.sv
`timescale 1ns/1ps
module tick_event_counter #(
  parameter int TCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  output logic              tick_o,
  output logic [TCNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o  <= 1'b0;
      count_o <= '0;
    end else begin
      tick_o <= hit_i;
      if (hit_i) count_o <= count_o + TCNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_tick_gen.sv
`timescale 1ns/1ps
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int TCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  base_i,
  input  logic [FRAC_W-1:0] frac_num_i,
  input  logic [FRAC_W-1:0] frac_den_i,
  output logic              tick_o,
  output logic [TCNT_W-1:0] tick_count_o
);
  tick_mode_e mode_e;
  logic       reload;
  logic       stretch;

  always_comb mode_e = tick_mode_e'(mode_i);

  tick_phase_accum #(.FRAC_W(FRAC_W)) phase_i (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (reload),
    .mode_i   (mode_e),
    .num_i    (frac_num_i),
    .den_i    (frac_den_i),
    .stretch_o(stretch)
  );

  tick_down_counter #(.CNT_W(CNT_W)) cdown_i (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .base_i   (base_i),
    .stretch_i(stretch),
    .expire_o (reload)
  );

  tick_event_counter #(.TCNT_W(TCNT_W)) events_i (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (reload),
    .tick_o (tick_o),
    .count_o(tick_count_o)
  );

  // R2: single-cycle pulse (input assumption: base_i >= 2)
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R2: the count steps by one exactly with each pulse
  a_r2_count_tracks_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (tick_count_o == $past(tick_count_o) + TCNT_W'(1)));

  a_r2_count_still_without_pulse: assert property (@(posedge clk) disable iff (rst)
    !tick_o |-> $stable(tick_count_o));

  // R7: disabled cycles produce no pulse
  a_r7_no_tick_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tick_o);
endmodule

// File: tb/frac_tick_gen_tb_top.sv
`timescale 1ns/1ps
module frac_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        mode = 1'b0;
  logic [15:0] base = 16'd32;
  logic [15:0] num = 16'd768;
  logic [15:0] den = 16'd1000;
  logic        tick;
  logic [31:0] tcount;

  logic        rst_w = 1'b1;
  logic        tick_w;
  logic [3:0]  tcount_w;

  int n_chk = 0;
  int n_fail = 0;
  int m_acc = 0;
  int exp_len = 32;
  longint m_cnt = 0;

  always #2.5 clk = ~clk;

  frac_tick_gen dut_i (
    .clk(clk), .rst(rst), .en_i(en), .mode_i(mode), .base_i(base),
    .frac_num_i(num), .frac_den_i(den), .tick_o(tick), .tick_count_o(tcount)
  );

  frac_tick_gen #(.TCNT_W(4)) dut_wrap_i (
    .clk(clk), .rst(rst_w), .en_i(1'b1), .mode_i(1'b0), .base_i(16'd3),
    .frac_num_i(16'd0), .frac_den_i(16'd1), .tick_o(tick_w), .tick_count_o(tcount_w)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // reference decision for the tick that starts at the reload just observed
  task automatic model_reload();
    int s;
    if (mode) begin
      s = m_acc + int'(num);
      if (s >= int'(den)) begin m_acc = s - int'(den); exp_len = int'(base) + 1; end
      else begin m_acc = s; exp_len = int'(base); end
    end else begin
      exp_len = int'(base);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 tick in reset", tick, 0);
    chk(tcount == 0, "R1 count in reset", tcount, 0);
    rst = 1'b0;
    m_acc = 0; m_cnt = 0; exp_len = int'(base);
  endtask

  task automatic wait_tick(inout int len);
    forever begin
      @(negedge clk);
      len++;
      if (tick || len > 100000) break;
    end
  endtask

  task automatic tick_step(input string req);
    int l = 0;
    wait_tick(l);
    chk(l == exp_len, req, l, exp_len);
    m_cnt++;
    chk(longint'(tcount) == (m_cnt & 64'hFFFF_FFFF), "R2 count", tcount, m_cnt);
    model_reload();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n33, total, l, saved;
    longint c0;
    // R1: reset state and first tick distance
    do_reset();
    tick_step("R1 first tick length");
    @(negedge clk);
    chk(tick == 1'b0, "R2 pulse width", tick, 0);
    l = 1;
    wait_tick(l);
    chk(l == 32, "R3 plain length after pulse check", l, 32);
    m_cnt++; model_reload();
    // R3: plain mode
    for (int i = 0; i < 20; i++) tick_step("R3 plain length");
    // R4/R5: corrected mode; first tick after switch is still plain
    mode = 1'b1;
    tick_step("R6 mode switch waits for reload");
    n33 = 0; total = 0;
    for (int i = 0; i < 1000; i++) begin
      if (exp_len == 33) n33++;
      total += exp_len;
      tick_step("R4 corrected length");
    end
    chk(n33 == 768, "R5 stretched ticks", n33, 768);
    chk(total == 32768, "R5 total cycles", total, 32768);
    // R6: change base and mode mid-tick
    l = 0;
    repeat (5) @(negedge clk);
    l = 5;
    saved = exp_len;
    base = 16'd40; mode = 1'b0;
    wait_tick(l);
    chk(l == saved, "R6 mid-tick change ignored", l, saved);
    m_cnt++;
    chk(longint'(tcount) == m_cnt, "R2 count", tcount, m_cnt);
    model_reload();
    tick_step("R6 new base after reload");
    // R7: enable gap of 10 cycles
    repeat (4) @(negedge clk);
    c0 = longint'(tcount);
    en = 1'b0;
    l = 4;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      l++;
      chk(tick == 1'b0, "R7 no tick while off", tick, 0);
    end
    chk(longint'(tcount) == c0, "R7 count held", tcount, c0);
    en = 1'b1;
    saved = exp_len + 10;
    wait_tick(l);
    chk(l == saved, "R7 tick delayed by gap", l, saved);
    m_cnt++;
    model_reload();
    // R4: sweep every numerator below a small denominator
    base = 16'd5; den = 16'd7;
    for (int n = 0; n < 7; n++) begin
      num = 16'(n); mode = 1'b1;
      do_reset();
      for (int i = 0; i < 15; i++) tick_step("R4 sweep length");
    end
    // R8: wrap of a 4-bit count
    rst_w = 1'b1;
    repeat (2) @(negedge clk);
    rst_w = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      l = 0;
      forever begin
        @(negedge clk);
        l++;
        if (tick_w || l > 1000) break;
      end
      if (i == 15) chk(tcount_w == 4'd15, "R8 count before wrap", tcount_w, 15);
      if (i == 16) chk(tcount_w == 4'd0, "R8 count wraps", tcount_w, 0);
    end
    summary();
  end
endmodule